// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of 32 general-purpose lines, grouped into four ports of eight lines each. Line n belongs to port n/8 and is pin n%8 of that port. Software reaches the bank through a 32-bit register interface with byte strobes. Through it, software sets each line's direction, its driven value and its alternate-function select, and it reads the synchronized input levels. Any line can latch a pending interrupt on a rising edge, a falling edge, or both.

Software clears a pending bit by writing a one to it. Pending lines reach several processor interrupt outputs. Each output has its own byte-wide enable masks, held in a second address window. A build parameter mirrors the order of the port bytes inside every register, so the bank can sit behind buses of either port order.

Top module: `edge_gpio_bank`

## Requirements
- R1: In the registers with one bit per line, port p uses byte lane p when `PORT_REV`=0 and byte lane 3-p when `PORT_REV`=1. Bit k of that byte is pin k of the port. Register offsets are: select 0x00, direction 0x08, data 0x0C, status 0x10. CPU c's enable word sits at `MASK_BASE`+4c.
- R2: A write to the direction register drives `gpio_oe`, and a write to the data register drives `gpio_out`. Only the byte lanes whose `bus_wstrb` bit is set change.
- R3: Reading the data register returns the driven value for output lines and the input level for input lines. An input level passes through two flops, so it is readable after the second rising clock edge that follows the pin change.
- R4: Each line has a 2-bit edge field: 00 off, 01 falling, 10 rising, 11 both. Port p's 16-bit slot starts at byte 2p of the pair 0x14/0x18 when `PORT_REV`=0, and at byte 2(p^1) when `PORT_REV`=1. Pin k occupies bits [2k+1:2k] of its slot, and each word is little-endian.
- R5: A qualifying edge sets the line's status bit, and only if the line's field enables that edge. The bit is visible, and the interrupt output is raised, after the third rising clock edge that follows the pin change.
- R6: Writing 1 to a status bit clears it. Writing 0, or writing to a lane whose strobe is low, leaves the bit unchanged.
- R7: If a new edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq[c]` is high exactly while some line is pending and enabled in CPU c's mask.
- R9: After reset, select, direction, data output, edge fields and status are zero, and every CPU mask bit is one.
- R10: A write to the select register drives `pin_sel` for each line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write enable, sampled at the rising edge |
| bus_addr | input | AW | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte lane strobes |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_in | input | 32 | Pin input levels, asynchronous |
| gpio_out | output | 32 | Driven values |
| gpio_oe | output | 32 | Output enables, 1 = output |
| pin_sel | output | 32 | Alternate-function select per line |
| irq | output | NCPU | Interrupt request per CPU |

## Verification
Register writes take effect at the edge that samples `bus_wr`. The bench therefore reads back, through the combinational read port, at the falling edge that follows the write.

A pin change reaches the data register after two rising edges and the status register after three. The bench drives each pin on a falling edge and reads after four falling edges, which safely covers both latencies. Two checks pin the exact timing: one shows that the data register still holds the old value after one edge and the new value after two. The other lines up a clearing write with the third edge of an input change, so that the edge and the clear land in the same cycle.

// File: rtl/egb_pkg.sv
package egb_pkg;

    localparam int PORTS  = 4;
    localparam int PW     = 8;
    localparam int LINES  = PORTS * PW;
    localparam int DW     = 32;

    localparam int OFF_SEL   = 'h00;
    localparam int OFF_DIR   = 'h08;
    localparam int OFF_DATA  = 'h0C;
    localparam int OFF_STAT  = 'h10;
    localparam int OFF_EDGE0 = 'h14;
    localparam int OFF_EDGE1 = 'h18;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    // Byte-order mirror between bus lanes and line-ordered vectors
    function automatic logic [DW-1:0] lane_swap(input logic [DW-1:0] x, input bit rev);
        return rev ? {x[7:0], x[15:8], x[23:16], x[31:24]} : x;
    endfunction

    // Which 16-bit half of its edge word a port occupies
    function automatic int edge_half(input int p, input bit rev);
        return (p % 2) ^ (rev ? 1 : 0);
    endfunction

endpackage

// File: rtl/egb_line_sync.sv
module egb_line_sync
    import egb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output logic     level,
    output edge_ev_t ev
);
    logic [STAGES-1:0] shreg;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            prev  <= 1'b0;
        end else begin
            shreg <= {shreg[STAGES-2:0], din};
            prev  <= shreg[STAGES-1];
        end
    end

    assign level   = shreg[STAGES-1];
    assign ev.rise = level & ~prev;
    assign ev.fall = ~level & prev;
endmodule

// File: rtl/egb_status.sv
module egb_status
    import egb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  edge_ev_t   [N-1:0]     ev,
    input  edge_mode_e [N-1:0]     mode,
    input  logic       [N-1:0]     clr,
    output logic       [N-1:0]     stat
);
    logic [N-1:0] hit;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit[i] = (ev[i].rise & mode[i][1]) | (ev[i].fall & mode[i][0]);
        end
    end

    // a new edge outranks a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr) | hit;
    end
endmodule

// File: rtl/egb_irq_route.sv
module egb_irq_route #(
    parameter int NCPU = 2,
    parameter int N    = 32
) (
    input  logic [N-1:0]            stat,
    input  logic [NCPU-1:0][N-1:0]  en,
    output logic [NCPU-1:0]         irq
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign irq[c] = |(stat & en[c]);
    end
endmodule

// File: rtl/edge_gpio_bank.sv
module edge_gpio_bank
    import egb_pkg::*;
#(
    parameter int            NCPU        = 2,
    parameter bit            PORT_REV    = 1'b0,
    parameter int            SYNC_STAGES = 2,
    parameter int            AW          = 8,
    parameter logic [AW-1:0] MASK_BASE   = 8'h40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [3:0]      bus_wstrb,
    output logic [DW-1:0]   bus_rdata,
    input  logic [LINES-1:0] gpio_in,
    output logic [LINES-1:0] gpio_out,
    output logic [LINES-1:0] gpio_oe,
    output logic [LINES-1:0] pin_sel,
    output logic [NCPU-1:0]  irq
);
    logic [LINES-1:0]             sel_q, dir_q, dout_q;
    logic [NCPU-1:0][LINES-1:0]   en_q;
    edge_mode_e [LINES-1:0]       mode_q;
    logic [LINES-1:0]             level, stat_w, clr;
    edge_ev_t [LINES-1:0]         ev;
    logic [LINES-1:0]             wline, sline;
    logic [1:0][DW-1:0]           edge_rd;
    logic                         wr_sel, wr_dir, wr_data, wr_stat;
    logic [1:0]                   wr_edge;
    logic [NCPU-1:0]              wr_mask;

    // bus data and strobes re-ordered into line order
    assign wline = lane_swap(bus_wdata, PORT_REV);
    assign sline = lane_swap({{8{bus_wstrb[3]}}, {8{bus_wstrb[2]}},
                              {8{bus_wstrb[1]}}, {8{bus_wstrb[0]}}}, PORT_REV);

    assign wr_sel     = bus_wr && (bus_addr == AW'(OFF_SEL));
    assign wr_dir     = bus_wr && (bus_addr == AW'(OFF_DIR));
    assign wr_data    = bus_wr && (bus_addr == AW'(OFF_DATA));
    assign wr_stat    = bus_wr && (bus_addr == AW'(OFF_STAT));
    assign wr_edge[0] = bus_wr && (bus_addr == AW'(OFF_EDGE0));
    assign wr_edge[1] = bus_wr && (bus_addr == AW'(OFF_EDGE1));
    for (genvar c = 0; c < NCPU; c++) begin : g_mhit
        assign wr_mask[c] = bus_wr && (bus_addr == AW'(MASK_BASE + 4 * c));
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        egb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .din   (gpio_in[n]),
            .level (level[n]),
            .ev    (ev[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            dir_q  <= '0;
            dout_q <= '0;
            en_q   <= '1;
            mode_q <= {LINES{EDGE_OFF}};
        end else begin
            if (wr_sel)  sel_q  <= (sel_q  & ~sline) | (wline & sline);
            if (wr_dir)  dir_q  <= (dir_q  & ~sline) | (wline & sline);
            if (wr_data) dout_q <= (dout_q & ~sline) | (wline & sline);
            for (int c = 0; c < NCPU; c++) begin
                if (wr_mask[c]) en_q[c] <= (en_q[c] & ~sline) | (wline & sline);
            end
            for (int p = 0; p < PORTS; p++) begin
                for (int k = 0; k < PW; k++) begin
                    if (wr_edge[p/2] && bus_wstrb[2*edge_half(p, PORT_REV) + k/4]) begin
                        mode_q[p*PW+k] <= edge_mode_e'(
                            bus_wdata[16*edge_half(p, PORT_REV) + 2*k +: 2]);
                    end
                end
            end
        end
    end

    assign clr = wr_stat ? (wline & sline) : '0;

    egb_status #(.N(LINES)) u_status (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .mode (mode_q),
        .clr  (clr),
        .stat (stat_w)
    );

    egb_irq_route #(.NCPU(NCPU), .N(LINES)) u_route (
        .stat (stat_w),
        .en   (en_q),
        .irq  (irq)
    );

    always_comb begin
        edge_rd = '0;
        for (int p = 0; p < PORTS; p++) begin
            for (int k = 0; k < PW; k++) begin
                edge_rd[p/2][16*edge_half(p, PORT_REV) + 2*k +: 2] = mode_q[p*PW+k];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_SEL))   bus_rdata = lane_swap(sel_q, PORT_REV);
        if (bus_addr == AW'(OFF_DIR))   bus_rdata = lane_swap(dir_q, PORT_REV);
        if (bus_addr == AW'(OFF_DATA))
            bus_rdata = lane_swap((dir_q & dout_q) | (~dir_q & level), PORT_REV);
        if (bus_addr == AW'(OFF_STAT))  bus_rdata = lane_swap(stat_w, PORT_REV);
        if (bus_addr == AW'(OFF_EDGE0)) bus_rdata = edge_rd[0];
        if (bus_addr == AW'(OFF_EDGE1)) bus_rdata = edge_rd[1];
        for (int c = 0; c < NCPU; c++) begin
            if (bus_addr == AW'(MASK_BASE + 4 * c)) bus_rdata = lane_swap(en_q[c], PORT_REV);
        end
    end

    assign gpio_out = dout_q;
    assign gpio_oe  = dir_q;
    assign pin_sel  = sel_q;
endmodule

// File: rtl/egb_checker.sv
module egb_checker #(
    parameter int NCPU  = 2,
    parameter int LINES = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic [LINES-1:0]            stat,
    input logic [2*LINES-1:0]          mode,
    input logic [NCPU-1:0][LINES-1:0]  en,
    input logic [NCPU-1:0]             irq,
    input logic                        wr_stat,
    input logic                        wr_dir,
    input logic [LINES-1:0]            oe
);
    logic [LINES-1:0] armed;

    always_comb begin
        for (int i = 0; i < LINES; i++) armed[i] = |mode[2*i +: 2];
    end

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat == '0 && oe == '0 && (&en)));

    // R5
    set_needs_field_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~$past(stat) & ~$past(armed)) == '0));

    // R6
    drop_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(stat) & ~stat) != '0) |-> $past(wr_stat)));

    // R8
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |-> (stat != '0));

    // R2
    oe_moves_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (oe != $past(oe)) |-> $past(wr_dir));
endmodule

bind edge_gpio_bank egb_checker #(.NCPU(NCPU), .LINES(egb_pkg::LINES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .stat    (stat_w),
    .mode    (mode_q),
    .en      (en_q),
    .irq     (irq),
    .wr_stat (wr_stat),
    .wr_dir  (wr_dir),
    .oe      (gpio_oe)
);

// File: tb/edge_gpio_bank_test.sv
`timescale 1ns/1ps
module edge_gpio_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr    [2];
    logic [7:0]  addr  [2];
    logic [31:0] wdata [2];
    logic [3:0]  strb  [2];
    logic [31:0] rdata [2];
    logic [31:0] gin   [2];
    logic [31:0] gout  [2];
    logic [31:0] goe   [2];
    logic [31:0] gsel  [2];
    logic [1:0]  irqv  [2];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_gpio_bank #(.NCPU(2), .PORT_REV(1'b0)) uut (
        .clk(clk), .rst(rst), .bus_wr(wr[0]), .bus_addr(addr[0]), .bus_wdata(wdata[0]),
        .bus_wstrb(strb[0]), .bus_rdata(rdata[0]), .gpio_in(gin[0]), .gpio_out(gout[0]),
        .gpio_oe(goe[0]), .pin_sel(gsel[0]), .irq(irqv[0]));

    edge_gpio_bank #(.NCPU(2), .PORT_REV(1'b1)) uut_rev (
        .clk(clk), .rst(rst), .bus_wr(wr[1]), .bus_addr(addr[1]), .bus_wdata(wdata[1]),
        .bus_wstrb(strb[1]), .bus_rdata(rdata[1]), .gpio_in(gin[1]), .gpio_out(gout[1]),
        .gpio_oe(goe[1]), .pin_sel(gsel[1]), .irq(irqv[1]));

    function automatic logic [31:0] bswap(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction
    function automatic logic [31:0] tobus(input int r, input logic [31:0] x);
        return (r == 1) ? bswap(x) : x;
    endfunction
    function automatic int busbit(input int r, input int n);
        return ((r == 1) ? 3 - n / 8 : n / 8) * 8 + n % 8;
    endfunction
    function automatic int eoff(input int r, input int n);
        int p = n / 8;
        return (r == 1) ? 2 * (p ^ 1) : 2 * p;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(input int r, input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr[r] = 1'b1; addr[r] = a; wdata[r] = d; strb[r] = s;
        @(negedge clk);
        wr[r] = 1'b0;
    endtask

    task automatic br(input int r, input logic [7:0] a, output logic [31:0] d);
        addr[r] = a;
        #1;
        d = rdata[r];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int r = 0; r < 2; r++) begin
            wr[r] = 0; addr[r] = 0; wdata[r] = 0; strb[r] = 0; gin[r] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int r = 0; r < 2; r++) begin
            // R9 reset values
            br(r, 8'h00, v); chk("R9 sel", v, 0);
            br(r, 8'h08, v); chk("R9 dir", v, 0);
            br(r, 8'h10, v); chk("R9 stat", v, 0);
            br(r, 8'h14, v); chk("R9 edge0", v, 0);
            br(r, 8'h18, v); chk("R9 edge1", v, 0);
            br(r, 8'h40, v); chk("R9 mask0", v, 32'hFFFF_FFFF);
            br(r, 8'h44, v); chk("R9 mask1", v, 32'hFFFF_FFFF);
            chk("R9 irq", {30'd0, irqv[r]}, 0);
            chk("R9 oe", goe[r], 0);

            // R1 R2 single-line direction sweep
            for (int k = 0; k < 32; k++) begin
                bw(r, 8'h08, 32'd1 << busbit(r, k), 4'hF);
                chk("R1 R2 oe line", goe[r], 32'd1 << k);
                br(r, 8'h08, v);
                chk("R1 dir readback", v, 32'd1 << busbit(r, k));
            end

            // R2 byte strobe gating
            bw(r, 8'h08, 0, 4'hF);
            bw(r, 8'h08, 32'hFFFF_FFFF, 4'b0100);
            chk("R2 strobe", goe[r], 32'hFF << (8 * ((r == 1) ? 1 : 2)));

            // R2 R3 data path
            bw(r, 8'h08, tobus(r, 32'h0000_FFFF), 4'hF);
            bw(r, 8'h0C, tobus(r, 32'h1234_ABCD), 4'hF);
            chk("R2 out", gout[r], 32'h1234_ABCD);
            @(negedge clk); gin[r] = 32'h5A5A_0000;
            repeat (3) @(negedge clk);
            br(r, 8'h0C, v);
            chk("R3 mixed read", v, tobus(r, 32'h5A5A_ABCD));
            gin[r] = 32'hC3C3_0000;
            @(negedge clk);
            br(r, 8'h0C, v);
            chk("R3 one edge old", v, tobus(r, 32'h5A5A_ABCD));
            @(negedge clk);
            br(r, 8'h0C, v);
            chk("R3 two edges new", v, tobus(r, 32'hC3C3_ABCD));
            gin[r] = 0;
            bw(r, 8'h08, 0, 4'hF);
            repeat (4) @(negedge clk);

            // R10 pin select
            bw(r, 8'h00, tobus(r, 32'hC3C3_0F0F), 4'hF);
            chk("R10 pin_sel", gsel[r], 32'hC3C3_0F0F);

            // R4 R5 exhaustive line x mode sweep
            for (int n = 0; n < 32; n++) begin
                for (int m = 0; m < 4; m++) begin
                    bw(r, 8'h14, 0, 4'hF);
                    bw(r, 8'h18, 0, 4'hF);
                    bw(r, 8'h14 + 8'((eoff(r, n) / 4) * 4),
                       32'(m) << ((eoff(r, n) % 4) * 8 + 2 * (n % 8)), 4'hF);
                    bw(r, 8'h10, 32'hFFFF_FFFF, 4'hF);
                    gin[r][n] = 1'b1;
                    repeat (4) @(negedge clk);
                    br(r, 8'h10, v);
                    chk("R4 R5 rise", v, m[1] ? (32'd1 << busbit(r, n)) : 0);
                    chk("R8 irq rise", {31'd0, irqv[r][0]}, {31'd0, m[1]});
                    bw(r, 8'h10, 32'hFFFF_FFFF, 4'hF);
                    gin[r][n] = 1'b0;
                    repeat (4) @(negedge clk);
                    br(r, 8'h10, v);
                    chk("R4 R5 fall", v, m[0] ? (32'd1 << busbit(r, n)) : 0);
                    chk("R8 irq fall", {31'd0, irqv[r][0]}, {31'd0, m[0]});
                    bw(r, 8'h10, 32'hFFFF_FFFF, 4'hF);
                end
            end

            // R6 write-one-to-clear
            bw(r, 8'h14 + 8'((eoff(r, 5) / 4) * 4),
               32'd3 << ((eoff(r, 5) % 4) * 8 + 10), 4'hF);
            gin[r][5] = 1'b1;
            repeat (4) @(negedge clk);
            bw(r, 8'h10, 0, 4'hF);
            br(r, 8'h10, v); chk("R6 zero write", v, 32'd1 << busbit(r, 5));
            bw(r, 8'h10, 32'hFFFF_FFFF, ~(4'd1 << (busbit(r, 5) / 8)));
            br(r, 8'h10, v); chk("R6 strobe off", v, 32'd1 << busbit(r, 5));
            bw(r, 8'h10, 32'd1 << busbit(r, 5), 4'hF);
            br(r, 8'h10, v); chk("R6 one clears", v, 0);

            // R7 set beats clear in the same cycle
            bw(r, 8'h14 + 8'((eoff(r, 9) / 4) * 4),
               32'd3 << ((eoff(r, 9) % 4) * 8 + 2), 4'hF);
            @(negedge clk); gin[r][9] = 1'b1;
            @(negedge clk);
            @(negedge clk);
            wr[r] = 1'b1; addr[r] = 8'h10; wdata[r] = 32'd1 << busbit(r, 9); strb[r] = 4'hF;
            @(negedge clk);
            wr[r] = 1'b0;
            br(r, 8'h10, v); chk("R7 set wins", v, 32'd1 << busbit(r, 9));
            bw(r, 8'h10, 32'hFFFF_FFFF, 4'hF);
            br(r, 8'h10, v); chk("R7 later clear", v, 0);

            // R8 per-CPU routing, line 20 pending
            bw(r, 8'h14 + 8'((eoff(r, 20) / 4) * 4),
               32'd2 << ((eoff(r, 20) % 4) * 8 + 8), 4'hF);
            gin[r][20] = 1'b1;
            repeat (4) @(negedge clk);
            bw(r, 8'h44, 0, 4'hF);
            chk("R8 cpu1 masked", {30'd0, irqv[r]}, 2'b01);
            bw(r, 8'h44, 32'd1 << busbit(r, 20), 4'hF);
            chk("R8 cpu1 line on", {30'd0, irqv[r]}, 2'b11);
            bw(r, 8'h40, tobus(r, ~(32'd1 << 20)), 4'hF);
            chk("R8 cpu0 line off", {30'd0, irqv[r]}, 2'b10);
            br(r, 8'h40, v); chk("R1 R8 mask readback", v, tobus(r, ~(32'd1 << 20)));
            bw(r, 8'h10, 32'hFFFF_FFFF, 4'hF);
            chk("R8 cleared", {30'd0, irqv[r]}, 2'b00);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule